// File: doc/BRIEF.md
# Mode-Selectable Bit-Slice ALU

This block is a small arithmetic/logic unit assembled from identical one-bit cells, repeated `W` times, with the carry passed from each cell to the next higher one. Every cell sees the same mode bit and the same two-bit function select. The low select bit inverts the A operand bit. The high select bit gates the B operand bit. One conditioning path therefore serves both a logic mode and an arithmetic mode.

With `mode` low, the cells combine the conditioned operands without a carry. This yields pass, complement, XOR and XNOR, the carry chain stays at zero, and `cin` is ignored. With `mode` high, the cells form a full sum of the conditioned A, the gated B and the rippled carry. This yields increment, negate, add and reverse-subtract results. The result word and the carry out of the top cell are captured in registers. A synchronous, active-high reset clears those registers.

Top module: `bitslice_alu`

## Requirements
- R1: While `rst` is high at a rising edge of `clk`, `f` and `cout` become 0 after that edge.
- R2: With `mode`=0, `f` is A for `sel`=00, NOT A for `sel`=01, A XOR B for `sel`=10 and A XNOR B for `sel`=11 (`sel[0]` inverts A, `sel[1]` gates B in).
- R3: With `mode`=0, `cout` is 0 and `cin` has no effect on `f`.
- R4: With `mode`=1 and `sel`=00, {`cout`,`f`} is A + `cin`.
- R5: With `mode`=1 and `sel`=01, {`cout`,`f`} is (NOT A) + `cin`, so `f` is the two's complement negation of A when `cin`=1.
- R6: With `mode`=1 and `sel`=10, {`cout`,`f`} is A + B + `cin`.
- R7: With `mode`=1 and `sel`=11, {`cout`,`f`} is (NOT A) + B + `cin`, which is B − A with `cout`=1 meaning no borrow when `cin`=1.
- R8: In arithmetic mode, `cout` is the carry out of the most significant cell, i.e. bit W of the (W+1)-bit sum.
- R9: Inputs sampled at one rising edge appear on `f` and `cout` after that same edge, and the outputs hold steady between edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset of the output registers |
| mode | input | 1 | 0 = logic operation, 1 = arithmetic operation |
| sel | input | 2 | Function select: bit 0 inverts A, bit 1 gates B |
| cin | input | 1 | Carry into the lowest cell (arithmetic mode only) |
| a | input | W | Operand A |
| b | input | W | Operand B |
| f | output | W | Registered result |
| cout | output | 1 | Registered carry out of the top cell |

## Verification
Every combination of mode, select and carry-in is tried with the operand extremes all-zero and all-ones, and also with random words. The extremes show whether the carry runs through the full chain, for example all-ones plus one and the negation of zero. Random words show up select bits that are wired to the wrong operand. Logic-mode cases are applied twice, once with each carry-in value, and the two results must be identical. This shows that no carry leaks into logic results. Subtract cases with B above and below A tell the borrow polarity of `cout` apart.

// File: rtl/alu_pkg.sv
package alu_pkg;
  // sel[0] inverts A, sel[1] gates B; the order is behavioural.
  typedef enum logic [1:0] {
    SEL_A      = 2'b00,
    SEL_NOTA   = 2'b01,
    SEL_AB     = 2'b10,
    SEL_NOTAB  = 2'b11
  } alu_sel_e;
endpackage

// File: rtl/alu_cell.sv
module alu_cell (
  input  logic m,
  input  logic inv_a,
  input  logic gate_b,
  input  logic ci,
  input  logic ai,
  input  logic bi,
  output logic fi,
  output logic co
);
  logic a_t, b_t;

  always_comb begin
    a_t = ai ^ inv_a;
    b_t = gate_b & bi;
    fi  = a_t ^ b_t ^ (m & ci);
    co  = m & ((a_t & b_t) | (ci & (a_t | b_t)));
  end
endmodule

// File: rtl/alu_chain.sv
module alu_chain #(
  parameter int W = 8
) (
  input  logic         m,
  input  logic [1:0]   sel,
  input  logic         cin,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] f,
  output logic         cout
);
  logic [W:0] c;

  assign c[0] = cin;

  for (genvar i = 0; i < W; i++) begin : g_cell
    alu_cell u_cell (
      .m     (m),
      .inv_a (sel[0]),
      .gate_b(sel[1]),
      .ci    (c[i]),
      .ai    (a[i]),
      .bi    (b[i]),
      .fi    (f[i]),
      .co    (c[i+1])
    );
  end

  assign cout = c[W];
endmodule

// File: rtl/bitslice_alu.sv
module bitslice_alu #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         mode,
  input  logic [1:0]   sel,
  input  logic         cin,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] f,
  output logic         cout
);
  logic [W-1:0] f_nxt;
  logic         c_nxt;

  alu_chain #(.W(W)) u_chain (
    .m   (mode),
    .sel (sel),
    .cin (cin),
    .a   (a),
    .b   (b),
    .f   (f_nxt),
    .cout(c_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      f    <= '0;
      cout <= 1'b0;
    end else begin
      f    <= f_nxt;
      cout <= c_nxt;
    end
  end
endmodule

// File: rtl/bitslice_alu_chk.sv
module bitslice_alu_chk
  import alu_pkg::*;
#(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         mode,
  input logic [1:0]   sel,
  input logic         cin,
  input logic [W-1:0] a,
  input logic [W-1:0] b,
  input logic [W-1:0] f,
  input logic         cout
);
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  logic rst_seen = 1'b0;
  always_ff @(posedge clk) rst_seen <= rst;

  // R1: outputs cleared after a reset edge
  always @(negedge clk) begin
    if (rst_seen) begin
      p_reset_clear_r1: assert (f == '0 && cout == 1'b0)
        else $error("reset did not clear outputs");
    end
  end

  p_logic_nocarry_r3: assert property (@(posedge clk) disable iff (rst)
    (!mode) |=> (cout == 1'b0));

  p_logic_pass_r2: assert property (@(posedge clk) disable iff (rst)
    (!mode && sel == SEL_A) |=> (f == $past(a)));

  p_logic_inv_r2: assert property (@(posedge clk) disable iff (rst)
    (!mode && sel == SEL_NOTA) |=> (f == ~$past(a)));

  // R6 and R8: full sum including top carry
  p_arith_add_r6: assert property (@(posedge clk) disable iff (rst)
    (mode && sel == SEL_AB) |=>
      ({cout, f} == ({1'b0, $past(a)} + {1'b0, $past(b)} + {{W{1'b0}}, $past(cin)})));

  p_arith_neg_r5: assert property (@(posedge clk) disable iff (rst)
    (mode && sel == SEL_NOTA && cin) |=> (f == (~$past(a) + ONE)));
endmodule

bind bitslice_alu bitslice_alu_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .mode(mode), .sel(sel), .cin(cin),
  .a(a), .b(b), .f(f), .cout(cout)
);

// File: tb/tb_bitslice_alu.sv
module tb_bitslice_alu;
  localparam int W = 8;
  localparam time CLK_PERIOD = 10;
  localparam int NV = 13;

  // {mode, sel, cin, a, b, exp_cout, exp_f}
  localparam logic [28:0] VEC [NV] = '{
    {1'b0, 2'b00, 1'b0, 8'hA5, 8'h3C, 1'b0, 8'hA5},
    {1'b0, 2'b01, 1'b1, 8'hA5, 8'h3C, 1'b0, 8'h5A},
    {1'b0, 2'b10, 1'b0, 8'hA5, 8'h3C, 1'b0, 8'h99},
    {1'b0, 2'b11, 1'b1, 8'hA5, 8'h3C, 1'b0, 8'h66},
    {1'b1, 2'b00, 1'b1, 8'hFF, 8'h00, 1'b1, 8'h00},
    {1'b1, 2'b00, 1'b0, 8'h7F, 8'h12, 1'b0, 8'h7F},
    {1'b1, 2'b01, 1'b1, 8'h05, 8'h00, 1'b0, 8'hFB},
    {1'b1, 2'b01, 1'b1, 8'h00, 8'h00, 1'b1, 8'h00},
    {1'b1, 2'b10, 1'b0, 8'hC8, 8'h64, 1'b1, 8'h2C},
    {1'b1, 2'b10, 1'b1, 8'hFF, 8'hFF, 1'b1, 8'hFF},
    {1'b1, 2'b11, 1'b1, 8'h10, 8'h30, 1'b1, 8'h20},
    {1'b1, 2'b11, 1'b1, 8'h30, 8'h10, 1'b0, 8'hE0},
    {1'b1, 2'b10, 1'b0, 8'h00, 8'h00, 1'b0, 8'h00}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mode = 1'b0;
  logic [1:0] sel = 2'b00;
  logic cin = 1'b0;
  logic [W-1:0] a = '0;
  logic [W-1:0] b = '0;
  logic [W-1:0] f;
  logic cout;

  int nchk = 0;
  int nbad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bitslice_alu #(.W(W)) dut (
    .clk(clk), .rst(rst), .mode(mode), .sel(sel), .cin(cin),
    .a(a), .b(b), .f(f), .cout(cout)
  );

  function automatic logic [W:0] model(input logic m, input logic [1:0] s,
                                       input logic c, input logic [W-1:0] x,
                                       input logic [W-1:0] y);
    logic [W-1:0] xa, yb;
    xa = s[0] ? ~x : x;
    yb = s[1] ? y : '0;
    if (m) return {1'b0, xa} + {1'b0, yb} + {{W{1'b0}}, c};
    return {1'b0, xa ^ yb};
  endfunction

  task automatic check(input string req, input logic [W:0] got, input logic [W:0] exp);
    nchk++;
    if (got !== exp) begin
      nbad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // drive at negedge, capture at posedge, sample at next negedge
  task automatic apply(input logic m, input logic [1:0] s, input logic c,
                       input logic [W-1:0] x, input logic [W-1:0] y);
    mode = m; sel = s; cin = c; a = x; b = y;
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic string req_of(input logic m, input logic [1:0] s);
    if (!m) return "R2";
    case (s)
      2'b00: return "R4";
      2'b01: return "R5";
      2'b10: return "R6 R8";
      default: return "R7";
    endcase
  endfunction

  initial begin
    #(CLK_PERIOD * 100000);
    nbad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
    $finish;
  end

  initial begin
    logic [W:0] r0, r1;
    @(negedge clk);
    a = 8'hFF; b = 8'hFF; mode = 1'b1; sel = 2'b10; cin = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check("R1 reset", {cout, f}, '0);
    rst = 1'b0;

    // table walk
    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][28], VEC[i][27:26], VEC[i][25], VEC[i][24:17], VEC[i][16:9]);
      check(req_of(VEC[i][28], VEC[i][27:26]), {cout, f}, VEC[i][8:0]);
    end

    // every mode/select/carry combination with extremes and random operands
    for (int m = 0; m < 2; m++) begin
      for (int s = 0; s < 4; s++) begin
        for (int c = 0; c < 2; c++) begin
          for (int k = 0; k < 6; k++) begin
            logic [W-1:0] x, y;
            case (k)
              0: begin x = '0; y = '0; end
              1: begin x = '1; y = '1; end
              2: begin x = '1; y = '0; end
              3: begin x = '0; y = '1; end
              default: begin x = W'($urandom); y = W'($urandom); end
            endcase
            apply(m[0], s[1:0], c[0], x, y);
            check(req_of(m[0], s[1:0]), {cout, f}, model(m[0], s[1:0], c[0], x, y));
          end
        end
      end
    end

    // R3: carry-in has no effect in logic mode, cout stays 0
    for (int s = 0; s < 4; s++) begin
      for (int k = 0; k < 4; k++) begin
        logic [W-1:0] x, y;
        x = (k == 0) ? '1 : W'($urandom);
        y = (k == 1) ? '1 : W'($urandom);
        apply(1'b0, s[1:0], 1'b0, x, y);
        r0 = {cout, f};
        apply(1'b0, s[1:0], 1'b1, x, y);
        r1 = {cout, f};
        check("R3 cin ignored", r1, r0);
        check("R3 cout zero", {8'h00, r1[W]}, '0);
      end
    end

    // R8: carry ripples through every cell
    apply(1'b1, 2'b00, 1'b1, 8'hFF, 8'h00);
    check("R8 full ripple", {cout, f}, 9'h100);
    apply(1'b1, 2'b10, 1'b0, 8'h80, 8'h80);
    check("R8 top carry", {cout, f}, 9'h100);

    // R9: outputs hold until the capturing edge
    apply(1'b1, 2'b10, 1'b0, 8'h01, 8'h02);
    mode = 1'b0; sel = 2'b01; a = 8'h0F;
    #1;
    check("R9 hold before edge", {cout, f}, 9'h003);
    @(posedge clk);
    @(negedge clk);
    check("R9 update after edge", {cout, f}, 9'h0F0);

    // R1: reset in mid-run with active inputs
    mode = 1'b1; sel = 2'b11; cin = 1'b1; a = 8'h01; b = 8'h80;
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check("R1 mid-run reset", {cout, f}, '0);
    rst = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check("R7 after reset", {cout, f}, 9'h17F);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
    $finish;
  end
endmodule